// File: doc/BRIEF.md
# Byte-Order Switching Register Bridge

This block sits on the path from a host's 32-bit register bus to a device's register space. It holds one byte-order flag. While the flag selects big-endian order, every access through the aperture has its four data bytes and its four byte enables mirrored. Write data and enables are mirrored on the way down to the device. Read data is mirrored on the way back up.

The block owns one control register of its own, at offset 0x004. A read of that register returns a fixed pattern that looks the same in either byte order. A write flips the flag when the data bit at position 24 is set, judged after any mirroring. As a result, the same host value flips the flag from either side. An address window, given on two input ports, marks a legacy region of 8-bit registers. Accesses inside that window always pass through unmirrored.

Requests use a valid/ready handshake. Accesses to the control register complete locally. All other accesses go straight to the device in the same cycle. The device is expected to present read data in the cycle after it accepts a read. The host sees every read response one cycle after the request is accepted.

Top module: `endian_bridge`

## Requirements
- R1: After reset the flag selects little-endian order, and a control register read returns 0x00000000.
- R2: A control register read returns 0x01000001 in big-endian order and 0x00000000 in little-endian order, the same value whatever the byte order.
- R3: A control register write flips the flag only when bit 24 of the data, after any mirroring, is 1 and byte lane 3 (enable bit 3, after any mirroring) is enabled. Any other control write leaves the flag unchanged.
- R4: In big-endian order, outside the window, write data reaches the device with its bytes reversed: host lane k goes to lane 3-k. Byte enable bit k goes to bit 3-k.
- R5: In big-endian order, outside the window, device read data reaches the host with its bytes reversed, in the same lane mapping as R4.
- R6: An access whose address lies in the window, from winBase up to and including winLimit, is never mirrored. Addresses just outside either end are mirrored.
- R7: In little-endian order, data and enables pass through unchanged in both directions.
- R8: A flag change applies from the access that directly follows the write that caused it.
- R9: Control register accesses are never forwarded to the device, and they are accepted even when the device is not ready.
- R10: Other requests are accepted only when devReady is high. A read response (hostRvalid) appears exactly one cycle after an accepted read, and never after a write or a request that was not accepted.
- R11: In big-endian order, a host write of 0x00000001 with enable 0x1 to the control register flips the flag, because mirroring moves the set bit to position 24 and the enable to lane 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostValid | input | 1 | Host request valid |
| hostReady | output | 1 | Request accepted this cycle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 16 | Byte address within the aperture |
| hostWdata | input | 32 | Host write data |
| hostBe | input | 4 | Host byte enables |
| hostRvalid | output | 1 | Read response valid |
| hostRdata | output | 32 | Read response data |
| winBase | input | 16 | First address of the unmirrored window |
| winLimit | input | 16 | Last address of the unmirrored window |
| devValid | output | 1 | Device request valid |
| devReady | input | 1 | Device ready to accept |
| devWrite | output | 1 | Device request is a write |
| devAddr | output | 16 | Device address |
| devWdata | output | 32 | Device write data, mirrored as needed |
| devBe | output | 4 | Device byte enables, mirrored as needed |
| devRdata | input | 32 | Device read data, valid the cycle after an accepted read |

## Verification
The hardest case to reach is the flip rule under big-endian order. There, a raw host value that would not flip the flag in little-endian order does flip it, and a value that looks correct is ignored if its enable falls on the wrong lane. The bench first enters big-endian order with the byte-symmetric pattern. It then issues the one-hot low-lane value and the misplaced-enable value, and reads the control register back after each write. For the window edges, the forwarding table places accesses at the first and last window addresses and at one address beyond each end, all in big-endian order.

// File: rtl/endian_bridge_pkg.sv
package endian_bridge_pkg;
  typedef struct packed {
    logic swapReq;   // mirror the current request
    logic rspValid;  // read response this cycle
    logic rspLocal;  // response comes from the control register
    logic rspSwap;   // mirror the response data
    logic rspMode;   // flag value captured with the read
  } bridgeStrobes_t;
endpackage

// File: rtl/endian_bridge_ctrl.sv
module endian_bridge_ctrl
  import endian_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 'h004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] winLimit,
  input  logic              devReady,
  input  logic              toggleBit,
  output logic              hostReady,
  output logic              devValid,
  output bridgeStrobes_t    strb
);
  logic bigMode;
  logic isCtrl, inWin, accept;
  logic rspValidQ, rspLocalQ, rspSwapQ, rspModeQ;

  assign isCtrl    = (hostAddr == CTRL_OFFSET);
  assign inWin     = (hostAddr >= winBase) && (hostAddr <= winLimit);
  assign hostReady = isCtrl || devReady;
  assign accept    = hostValid && hostReady;
  assign devValid  = hostValid && !isCtrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      bigMode   <= 1'b0;
      rspValidQ <= 1'b0;
      rspLocalQ <= 1'b0;
      rspSwapQ  <= 1'b0;
      rspModeQ  <= 1'b0;
    end else begin
      rspValidQ <= accept && !hostWrite;
      rspLocalQ <= isCtrl;
      rspSwapQ  <= bigMode && !inWin;
      rspModeQ  <= bigMode;
      if (accept && hostWrite && isCtrl && toggleBit)
        bigMode <= ~bigMode;
    end
  end

  always_comb begin
    strb.swapReq  = bigMode && !inWin;
    strb.rspValid = rspValidQ;
    strb.rspLocal = rspLocalQ;
    strb.rspSwap  = rspSwapQ;
    strb.rspMode  = rspModeQ;
  end

  assert_reset_little_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !bigMode);
  assert_flip_on_mark_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && hostWrite && isCtrl && toggleBit) |=> (bigMode != $past(bigMode)));
  assert_hold_otherwise_R3: assert property (@(posedge clk) disable iff (rst)
    !(accept && hostWrite && isCtrl && toggleBit) |=> $stable(bigMode));
endmodule

// File: rtl/endian_bridge_dp.sv
module endian_bridge_dp
  import endian_bridge_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  bridgeStrobes_t        strb,
  input  logic [DATA_W-1:0]     hostWdata,
  input  logic [DATA_W/8-1:0]   hostBe,
  input  logic [DATA_W-1:0]     devRdata,
  output logic [DATA_W-1:0]     devWdata,
  output logic [DATA_W/8-1:0]   devBe,
  output logic [DATA_W-1:0]     hostRdata,
  output logic                  toggleBit
);
  localparam int LANES = DATA_W / 8;
  localparam int FLIP_POS = DATA_W - 8;
  localparam logic [DATA_W-1:0] MODE_MARK =
    ({{(DATA_W-1){1'b0}}, 1'b1} << FLIP_POS) | {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] revW, revR, rspRaw;
  logic [LANES-1:0]  revBe;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign revW[i*8 +: 8] = hostWdata[(LANES-1-i)*8 +: 8];
    assign revR[i*8 +: 8] = rspRaw[(LANES-1-i)*8 +: 8];
    assign revBe[i]       = hostBe[LANES-1-i];
  end

  assign devWdata  = strb.swapReq ? revW : hostWdata;
  assign devBe     = strb.swapReq ? revBe : hostBe;
  assign toggleBit = devWdata[FLIP_POS] && devBe[LANES-1];

  assign rspRaw    = strb.rspLocal ? (strb.rspMode ? MODE_MARK : '0) : devRdata;
  assign hostRdata = strb.rspSwap ? revR : rspRaw;

  assert_mark_value_R2: assert property (@(posedge clk) disable iff (rst)
    (strb.rspValid && strb.rspLocal) |-> (hostRdata == '0 || hostRdata == MODE_MARK));
endmodule

// File: rtl/endian_bridge.sv
module endian_bridge
  import endian_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 'h004
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hostValid,
  output logic                hostReady,
  input  logic                hostWrite,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [DATA_W-1:0]   hostWdata,
  input  logic [DATA_W/8-1:0] hostBe,
  output logic                hostRvalid,
  output logic [DATA_W-1:0]   hostRdata,
  input  logic [ADDR_W-1:0]   winBase,
  input  logic [ADDR_W-1:0]   winLimit,
  output logic                devValid,
  input  logic                devReady,
  output logic                devWrite,
  output logic [ADDR_W-1:0]   devAddr,
  output logic [DATA_W-1:0]   devWdata,
  output logic [DATA_W/8-1:0] devBe,
  input  logic [DATA_W-1:0]   devRdata
);
  bridgeStrobes_t strb;
  logic toggleBit;

  endian_bridge_ctrl #(.ADDR_W(ADDR_W), .CTRL_OFFSET(CTRL_OFFSET)) u_ctrl (
    .clk(clk), .rst(rst), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .winBase(winBase), .winLimit(winLimit),
    .devReady(devReady), .toggleBit(toggleBit), .hostReady(hostReady),
    .devValid(devValid), .strb(strb)
  );

  endian_bridge_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .hostWdata(hostWdata), .hostBe(hostBe),
    .devRdata(devRdata), .devWdata(devWdata), .devBe(devBe),
    .hostRdata(hostRdata), .toggleBit(toggleBit)
  );

  assign devWrite   = hostWrite;
  assign devAddr    = hostAddr;
  assign hostRvalid = strb.rspValid;

  assert_ctrl_local_R9: assert property (@(posedge clk) disable iff (rst)
    (hostValid && hostAddr == CTRL_OFFSET) |-> (!devValid && hostReady));
  assert_rsp_timing_R10: assert property (@(posedge clk) disable iff (rst)
    hostRvalid |-> $past(hostValid && hostReady && !hostWrite));
endmodule

// File: tb/endian_bridge_test.sv
`timescale 1ns/1ps
module endian_bridge_test;
  logic        clk = 0;
  logic        rst;
  logic        hostValid, hostWrite, devReady;
  logic [15:0] hostAddr, winBase, winLimit;
  logic [31:0] hostWdata, devRdata;
  logic [3:0]  hostBe;
  logic        hostReady, hostRvalid, devValid, devWrite;
  logic [31:0] hostRdata, devWdata;
  logic [15:0] devAddr;
  logic [3:0]  devBe;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  endian_bridge uut (
    .clk(clk), .rst(rst), .hostValid(hostValid), .hostReady(hostReady),
    .hostWrite(hostWrite), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostBe(hostBe), .hostRvalid(hostRvalid), .hostRdata(hostRdata),
    .winBase(winBase), .winLimit(winLimit), .devValid(devValid),
    .devReady(devReady), .devWrite(devWrite), .devAddr(devAddr),
    .devWdata(devWdata), .devBe(devBe), .devRdata(devRdata)
  );

  localparam logic [15:0] CTRL = 16'h0004;

  typedef struct packed {
    logic        big;
    logic [15:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic [31:0] expData;
    logic [3:0]  expBe;
  } vecT;

  localparam vecT TABLE [9] = '{
    '{1'b0, 16'h0010, 32'h11223344, 4'hF, 32'h11223344, 4'hF},
    '{1'b0, 16'h0020, 32'hDEADBEEF, 4'h3, 32'hDEADBEEF, 4'h3},
    '{1'b1, 16'h0010, 32'h11223344, 4'h3, 32'h44332211, 4'hC},
    '{1'b1, 16'h0030, 32'hA0B0C0D0, 4'h1, 32'hD0C0B0A0, 4'h8},
    '{1'b1, 16'h0100, 32'h11223344, 4'h3, 32'h11223344, 4'h3},
    '{1'b1, 16'h01FF, 32'h55667788, 4'h1, 32'h55667788, 4'h1},
    '{1'b1, 16'h0200, 32'h55667788, 4'h1, 32'h88776655, 4'h8},
    '{1'b1, 16'h00FF, 32'h01020304, 4'h6, 32'h04030201, 4'h6},
    '{1'b0, 16'h0150, 32'hCAFEF00D, 4'hE, 32'hCAFEF00D, 4'hE}
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  logic        fwdValid, fwdReady, rspV;
  logic [31:0] fwdData, rspData;
  logic [3:0]  fwdBe;

  task automatic access(input logic w, input logic [15:0] a,
                        input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    hostValid = 1; hostWrite = w; hostAddr = a; hostWdata = d; hostBe = b;
    #1;
    fwdValid = devValid; fwdReady = hostReady; fwdData = devWdata; fwdBe = devBe;
    @(negedge clk);
    hostValid = 0;
    rspV = hostRvalid; rspData = hostRdata;
  endtask

  task automatic readCtrl(output logic [31:0] v);
    access(1'b0, CTRL, 32'h0, 4'hF);
    v = rspData;
  endtask

  task automatic setMode(input logic big);
    logic [31:0] v;
    readCtrl(v);
    if ((v != 0) != big) access(1'b1, CTRL, 32'h01000001, 4'hF);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1; hostValid = 0; hostWrite = 0; hostAddr = 0; hostWdata = 0; hostBe = 0;
    devReady = 1; devRdata = 0; winBase = 16'h0100; winLimit = 16'h01FF;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    readCtrl(v);
    check("R1 reset mode", v, 32'h0);
    check("R10 rvalid after read", {31'b0, rspV}, 32'h1);

    // R3 writes without the flip mark
    access(1'b1, CTRL, 32'h00000000, 4'hF);
    check("R10 no rvalid after write", {31'b0, rspV}, 32'h0);
    check("R9 ctrl not forwarded", {31'b0, fwdValid}, 32'h0);
    readCtrl(v); check("R3 zero write ignored", v, 32'h0);
    access(1'b1, CTRL, 32'h01000000, 4'h7);
    readCtrl(v); check("R3 lane3 disabled ignored", v, 32'h0);

    // R9 ctrl accepted while device busy; R3/R2 flip to big
    devReady = 0;
    access(1'b1, CTRL, 32'h01000000, 4'hF);
    check("R9 ctrl ready while busy", {31'b0, fwdReady}, 32'h1);
    devReady = 1;
    readCtrl(v); check("R2 big mode value", v, 32'h01000001);

    // R11 misplaced enable ignored, low-lane value flips
    access(1'b1, CTRL, 32'h00000001, 4'h8);
    readCtrl(v); check("R11 wrong lane ignored", v, 32'h01000001);
    access(1'b1, CTRL, 32'h00000001, 4'h1);
    readCtrl(v); check("R11 mirrored flip to little", v, 32'h0);

    // R8 change takes effect on the next access
    access(1'b1, CTRL, 32'h01000001, 4'hF);
    access(1'b1, 16'h0010, 32'h11223344, 4'hF);
    check("R8 next access mirrored", fwdData, 32'h44332211);

    // R4 R5 R6 R7 forwarding table
    foreach (TABLE[i]) begin
      setMode(TABLE[i].big);
      access(1'b1, TABLE[i].addr, TABLE[i].data, TABLE[i].be);
      check($sformatf("R4/R6/R7 row%0d wdata", i), fwdData, TABLE[i].expData);
      check($sformatf("R4/R6/R7 row%0d be", i), {28'b0, fwdBe}, {28'b0, TABLE[i].expBe});
      devRdata = TABLE[i].data;
      access(1'b0, TABLE[i].addr, 32'h0, 4'hF);
      check($sformatf("R5/R6/R7 row%0d rdata", i), rspData, TABLE[i].expData);
    end

    // R10 device not ready: not accepted, no response
    devReady = 0;
    access(1'b0, 16'h0040, 32'h0, 4'hF);
    check("R10 not ready", {31'b0, fwdReady}, 32'h0);
    check("R10 no response when stalled", {31'b0, rspV}, 32'h0);
    check("R10 forwarded valid", {31'b0, fwdValid}, 32'h1);
    devReady = 1;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule